// File: doc/BRIEF.md
# SDLC Transmit Tail and RTS Release Controller

This block sits at the serial end of a bit-oriented synchronous transmitter. It clocks frame data out on TxD. When the transmitter runs dry (underrun or end of message), it sends the frame's check field and then a closing flag. It also drives the active-low request-to-send pin for the modem or line driver.

Software usually drops its request-to-send bit while it handles the underrun, well before the check field and flag have gone out. When the auto-release feature is qualified, the block does not release the pin at that moment. It keeps the pin low until the trailing zero of the closing flag has fully left TxD, and releases it on that bit's ending strobe edge. The feature is qualified only when all of these hold: SDLC operation is selected, the auto-release enable is set, the flag-idle setting is 1 and the alternate-idle setting is 0. In every other case the pin tracks the request bit on the next clock edge.

The sequencer has four named states. IDLE sends mark, DATA passes shifter bits, CRC sends the captured check field and FLAG sends the closing flag. Its transitions are:
- IDLE to DATA on a strobe with `frame_go`.
- DATA to CRC on a strobe with `underrun`.
- CRC to FLAG on the strobe after the last check bit.
- FLAG to IDLE on the strobe that ends the last flag bit.

Top module: `sdlc_rts_tail`

## Requirements
- R1: After reset, `rts_n` is 1 (released) and `txd` is 1 (mark).
- R2: The hold feature is active only while `ctl_sdlc`=1, `ctl_auto_rts`=1, `ctl_flag_idle`=1 and `ctl_alt_idle`=0. Any other combination disables it.
- R3: With the feature inactive, `rts_n` equals the inverse of `rts_req` one clock edge later, in every state.
- R4: `rts_req`=1 makes `rts_n` 0 on the next clock edge, whatever the mode.
- R5: `txd` changes only on edges where `bit_stb`=1. A strobe in IDLE with `frame_go`=1 enters DATA, and each DATA strobe (without `underrun`) puts `data_bit` on `txd`.
- R6: A strobe in DATA with `underrun`=1 captures `crc_in` and starts the check field. `txd` then carries the CRC_W captured bits LSB first, one per strobe. Later changes of `crc_in` have no effect.
- R7: After the check field, `txd` carries the closing flag 0x7E LSB first (0,1,1,1,1,1,1,0). The following strobe returns `txd` to 1 and the sequencer to IDLE.
- R8: With the feature active and `rts_n` low, clearing `rts_req` at any point in CRC or FLAG keeps `rts_n` at 0. It rises on exactly the strobe edge that ends the final flag zero, the same edge on which `txd` returns to 1.
- R9: Clearing `rts_req` while no tail is pending (IDLE, DATA, or after the flag) releases `rts_n` on the next edge, even with the feature active.
- R10: `txd` is 1 whenever the sequencer is in IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rts_req | input | 1 | Software request-to-send bit (1 = request) |
| ctl_sdlc | input | 1 | SDLC operation selected |
| ctl_auto_rts | input | 1 | Auto-release feature enable |
| ctl_flag_idle | input | 1 | Flag-idle setting, must be 1 for the feature |
| ctl_alt_idle | input | 1 | Alternate-idle setting, must be 0 for the feature |
| bit_stb | input | 1 | Bit-boundary strobe from the serial shifter |
| frame_go | input | 1 | Start a frame at the next strobe while idle |
| data_bit | input | 1 | Serial frame data bit from the shifter |
| underrun | input | 1 | Underrun / end-of-message, starts the tail |
| crc_in | input | CRC_W | Check field value, captured on underrun |
| txd | output | 1 | Serial transmit data |
| rts_n | output | 1 | Request-to-send pin, active low |

## Verification
The bench clears the request in the check field, inside the flag and after the flag has ended. It also clears it in DATA before any underrun, and repeats the runs with strobes spaced one and two clocks apart.
- A design that released one strobe early would let the pin rise while the final zero is still on the line.
- A design that released one strobe late, or held after the tail, would keep the pin low into idle.
- A design that checked only part of the four qualifying settings would hold the pin in a mode where it should track the request at once.
- Changing `crc_in` after the underrun exposes a check field taken live rather than captured.

// File: rtl/sdlc_rts_pkg.sv
package sdlc_rts_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DATA,
        ST_CRC,
        ST_FLAG
    } tail_state_e;

    localparam int          FLAG_BITS  = 8;
    localparam logic [7:0]  CLOSE_FLAG = 8'h7E;

endpackage

// File: rtl/sdlc_rts_qual.sv
module sdlc_rts_qual (
    input  logic ctl_sdlc,
    input  logic ctl_auto_rts,
    input  logic ctl_flag_idle,
    input  logic ctl_alt_idle,
    output logic feat_on
);

    // All four settings must agree before the hold is allowed
    always_comb begin
        feat_on = ctl_sdlc & ctl_auto_rts & ctl_flag_idle & ~ctl_alt_idle;
    end

endmodule

// File: rtl/sdlc_tail_seq.sv
module sdlc_tail_seq
    import sdlc_rts_pkg::*;
#(
    parameter int CRC_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_stb,
    input  logic              frame_go,
    input  logic              data_bit,
    input  logic              underrun,
    input  logic [CRC_W-1:0]  crc_in,
    output logic              txd,
    output tail_state_e       state_q,
    output logic              tail_next
);

    localparam int MAX_CNT = (CRC_W > FLAG_BITS) ? CRC_W : FLAG_BITS;
    localparam int CNT_W   = $clog2(MAX_CNT + 1);

    tail_state_e       state_d;
    logic [CNT_W-1:0]  idx_q;
    logic [CRC_W-1:0]  crc_sh_q;
    logic [7:0]        flag_sh_q;
    logic              txd_q;
    logic              crc_last;
    logic              flag_last;

    assign crc_last  = (idx_q == CNT_W'(CRC_W));
    assign flag_last = (idx_q == CNT_W'(FLAG_BITS));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (bit_stb && frame_go)  state_d = ST_DATA;
            ST_DATA: if (bit_stb && underrun)  state_d = ST_CRC;
            ST_CRC:  if (bit_stb && crc_last)  state_d = ST_FLAG;
            ST_FLAG: if (bit_stb && flag_last) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    assign tail_next = (state_d == ST_CRC) || (state_d == ST_FLAG);

    // Serial output path, advanced only on bit boundaries
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            txd_q     <= 1'b1;
            idx_q     <= '0;
            crc_sh_q  <= '0;
            flag_sh_q <= '0;
        end else if (bit_stb) begin
            unique case (state_q)
                ST_IDLE: begin
                    txd_q <= frame_go ? data_bit : 1'b1;
                    idx_q <= '0;
                end
                ST_DATA: begin
                    if (underrun) begin
                        txd_q    <= crc_in[0];
                        crc_sh_q <= crc_in >> 1;
                        idx_q    <= CNT_W'(1);
                    end else begin
                        txd_q <= data_bit;
                    end
                end
                ST_CRC: begin
                    if (crc_last) begin
                        txd_q     <= CLOSE_FLAG[0];
                        flag_sh_q <= CLOSE_FLAG >> 1;
                        idx_q     <= CNT_W'(1);
                    end else begin
                        txd_q    <= crc_sh_q[0];
                        crc_sh_q <= crc_sh_q >> 1;
                        idx_q    <= idx_q + CNT_W'(1);
                    end
                end
                ST_FLAG: begin
                    if (flag_last) begin
                        txd_q <= 1'b1;
                        idx_q <= '0;
                    end else begin
                        txd_q     <= flag_sh_q[0];
                        flag_sh_q <= flag_sh_q >> 1;
                        idx_q     <= idx_q + CNT_W'(1);
                    end
                end
                default: begin
                    txd_q <= 1'b1;
                    idx_q <= '0;
                end
            endcase
        end
    end

    assign txd = txd_q;

endmodule

// File: rtl/sdlc_rts_hold.sv
module sdlc_rts_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic rts_req,
    input  logic feat_on,
    input  logic tail_next,
    output logic rts_n
);

    logic rts_n_q;
    logic hold;

    // Keep an already-asserted pin low while the tail continues past this edge
    assign hold = feat_on & ~rts_n_q & tail_next;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rts_n_q <= 1'b1;
        end else begin
            rts_n_q <= ~(rts_req | hold);
        end
    end

    assign rts_n = rts_n_q;

endmodule

// File: rtl/sdlc_rts_tail.sv
module sdlc_rts_tail
    import sdlc_rts_pkg::*;
#(
    parameter int CRC_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rts_req,
    input  logic              ctl_sdlc,
    input  logic              ctl_auto_rts,
    input  logic              ctl_flag_idle,
    input  logic              ctl_alt_idle,
    input  logic              bit_stb,
    input  logic              frame_go,
    input  logic              data_bit,
    input  logic              underrun,
    input  logic [CRC_W-1:0]  crc_in,
    output logic              txd,
    output logic              rts_n
);

    logic        feat_on;
    logic        tail_next;
    tail_state_e seq_state;

    sdlc_rts_qual u_qual (
        .ctl_sdlc      (ctl_sdlc),
        .ctl_auto_rts  (ctl_auto_rts),
        .ctl_flag_idle (ctl_flag_idle),
        .ctl_alt_idle  (ctl_alt_idle),
        .feat_on       (feat_on)
    );

    sdlc_tail_seq #(
        .CRC_W (CRC_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_stb   (bit_stb),
        .frame_go  (frame_go),
        .data_bit  (data_bit),
        .underrun  (underrun),
        .crc_in    (crc_in),
        .txd       (txd),
        .state_q   (seq_state),
        .tail_next (tail_next)
    );

    sdlc_rts_hold u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .rts_req   (rts_req),
        .feat_on   (feat_on),
        .tail_next (tail_next),
        .rts_n     (rts_n)
    );

endmodule

// File: rtl/sdlc_rts_tail_chk.sv
module sdlc_rts_tail_chk
    import sdlc_rts_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        rts_req,
    input logic        ctl_sdlc,
    input logic        ctl_auto_rts,
    input logic        ctl_flag_idle,
    input logic        ctl_alt_idle,
    input logic        bit_stb,
    input logic        txd,
    input logic        rts_n,
    input tail_state_e state_q
);

    logic qual;
    logic in_tail;

    assign qual    = ctl_sdlc && ctl_auto_rts && ctl_flag_idle && !ctl_alt_idle;
    assign in_tail = (state_q == ST_CRC) || (state_q == ST_FLAG);

    AST_REQ_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        rts_req |=> !rts_n);  // R4

    AST_UNQUALIFIED_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        !qual |=> (rts_n == !$past(rts_req)));  // R3

    AST_HOLD_BETWEEN_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
        (qual && !rts_n && in_tail && !bit_stb) |=> !rts_n);  // R8

    AST_RELEASE_AFTER_LAST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rts_n) && $past(qual) && $past(in_tail)) |-> (!$past(txd) && state_q == ST_IDLE));  // R8

    AST_TXD_STABLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_stb |=> $stable(txd));  // R5

    AST_IDLE_IS_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> txd);  // R10

endmodule

bind sdlc_rts_tail sdlc_rts_tail_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rts_req       (rts_req),
    .ctl_sdlc      (ctl_sdlc),
    .ctl_auto_rts  (ctl_auto_rts),
    .ctl_flag_idle (ctl_flag_idle),
    .ctl_alt_idle  (ctl_alt_idle),
    .bit_stb       (bit_stb),
    .txd           (txd),
    .rts_n         (rts_n),
    .state_q       (seq_state)
);

// File: tb/test_sdlc_rts_tail.sv
module test_sdlc_rts_tail;

    localparam int CLK_PERIOD = 10;
    localparam int CRC_W      = 16;
    localparam int NDATA      = 4;
    localparam int TAIL_END   = NDATA + CRC_W + 8;
    localparam logic [7:0] FLAG_PAT = 8'h7E;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             rts_req;
    logic             ctl_sdlc, ctl_auto_rts, ctl_flag_idle, ctl_alt_idle;
    logic             bit_stb, frame_go, data_bit, underrun;
    logic [CRC_W-1:0] crc_in;
    logic             txd, rts_n;

    int   n_vec = 0;
    int   n_bad = 0;
    logic exp_rts_n;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdlc_rts_tail #(.CRC_W(CRC_W)) i_sdlc_rts_tail (
        .clk           (clk),
        .rst_n         (rst_n),
        .rts_req       (rts_req),
        .ctl_sdlc      (ctl_sdlc),
        .ctl_auto_rts  (ctl_auto_rts),
        .ctl_flag_idle (ctl_flag_idle),
        .ctl_alt_idle  (ctl_alt_idle),
        .bit_stb       (bit_stb),
        .frame_go      (frame_go),
        .data_bit      (data_bit),
        .underrun      (underrun),
        .crc_in        (crc_in),
        .txd           (txd),
        .rts_n         (rts_n)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic set_cfg(input logic s, input logic a, input logic f, input logic alt);
        ctl_sdlc      = s;
        ctl_auto_rts  = a;
        ctl_flag_idle = f;
        ctl_alt_idle  = alt;
    endtask

    function automatic logic exp_bit(input int k, input logic [NDATA-1:0] dat,
                                     input logic [CRC_W-1:0] crc);
        if (k < NDATA)               return dat[k];
        else if (k < NDATA + CRC_W)  return crc[k - NDATA];
        else if (k < TAIL_END)       return FLAG_PAT[k - NDATA - CRC_W];
        else                         return 1'b1;
    endfunction

    function automatic string txd_tag(input int k);
        if (k < NDATA)              return "R5 data";
        else if (k < NDATA + CRC_W) return "R6 crc";
        else if (k < TAIL_END)      return "R7 flag";
        else                        return "R7 R10 mark";
    endfunction

    // One frame: slots are strobe edges; gap non-strobe clocks precede each slot
    task automatic run_frame(input logic [NDATA-1:0] dat, input logic [CRC_W-1:0] crc,
                             input int clr_slot, input int gap, input string rtag);
        logic feat;
        logic prev_txd;
        logic exp_txd;
        logic tail_now;
        feat     = ctl_sdlc && ctl_auto_rts && ctl_flag_idle && !ctl_alt_idle;
        prev_txd = 1'b1;
        bit_stb  = 1'b0;
        frame_go = 1'b0;
        underrun = 1'b0;
        rts_req  = 1'b1;
        step();
        chk("R4 request asserts pin", rts_n, 1'b0);
        exp_rts_n = 1'b0;
        for (int k = 0; k <= TAIL_END + 2; k++) begin
            if (k == clr_slot) rts_req = 1'b0;
            for (int g = 0; g < gap; g++) begin
                bit_stb  = 1'b0;
                frame_go = 1'b0;
                underrun = 1'b0;
                step();
                tail_now  = (k >= NDATA + 1) && (k <= TAIL_END);
                exp_rts_n = !(rts_req || (feat && !exp_rts_n && tail_now));
                chk("R5 txd holds without strobe", txd, prev_txd);
                chk(rtag, rts_n, exp_rts_n);
            end
            bit_stb  = 1'b1;
            frame_go = (k == 0);
            underrun = (k == NDATA);
            data_bit = (k < NDATA) ? dat[k] : 1'b0;
            crc_in   = (k == NDATA) ? crc : ~crc;
            step();
            tail_now  = (k >= NDATA) && (k < TAIL_END);
            exp_rts_n = !(rts_req || (feat && !exp_rts_n && tail_now));
            exp_txd   = exp_bit(k, dat, crc);
            chk(txd_tag(k), txd, exp_txd);
            chk(rtag, rts_n, exp_rts_n);
            prev_txd = exp_txd;
        end
        bit_stb  = 1'b0;
        frame_go = 1'b0;
        underrun = 1'b0;
        rts_req  = 1'b0;
        step();
        chk("R9 idle release", rts_n, 1'b1);
    endtask

    // Scenario tasks, each checking its own results inside run_frame
    task automatic t_reset();
        chk("R1 rts_n after reset", rts_n, 1'b1);
        chk("R1 txd after reset", txd, 1'b1);
    endtask

    task automatic t_early_clear_crc();
        set_cfg(1, 1, 1, 0);
        run_frame(4'b1011, 16'hA5C3, NDATA + 3, 0, "R8 early clear in crc");
    endtask

    task automatic t_early_clear_flag_gap();
        set_cfg(1, 1, 1, 0);
        run_frame(4'b0110, 16'h3C81, NDATA + CRC_W + 5, 1, "R8 early clear in flag");
    endtask

    task automatic t_clear_on_last_bit();
        set_cfg(1, 1, 1, 0);
        run_frame(4'b1001, 16'hFFFE, TAIL_END - 1, 2, "R8 clear at final zero");
    endtask

    task automatic t_late_clear();
        set_cfg(1, 1, 1, 0);
        run_frame(4'b1100, 16'h1234, TAIL_END + 2, 0, "R8 R9 late clear");
    endtask

    task automatic t_clear_in_data();
        set_cfg(1, 1, 1, 0);
        run_frame(4'b0101, 16'h8001, 2, 0, "R9 clear before tail");
    endtask

    task automatic t_unqualified();
        set_cfg(1, 1, 1, 1);
        run_frame(4'b1110, 16'hBEEF, NDATA + 3, 0, "R2 R3 alt idle set");
        set_cfg(0, 1, 1, 0);
        run_frame(4'b0011, 16'h0F0F, NDATA + CRC_W + 2, 2, "R2 R3 not sdlc");
        set_cfg(1, 1, 0, 0);
        run_frame(4'b1010, 16'h7E7E, NDATA + 10, 0, "R2 R3 flag idle clear");
        set_cfg(1, 0, 1, 0);
        run_frame(4'b0001, 16'hC0DE, NDATA + 12, 1, "R2 R3 auto disabled");
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        rst_n    = 1'b0;
        rts_req  = 1'b0;
        bit_stb  = 1'b0;
        frame_go = 1'b0;
        data_bit = 1'b0;
        underrun = 1'b0;
        crc_in   = '0;
        set_cfg(1, 1, 1, 0);
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_early_clear_crc();
        t_early_clear_flag_gap();
        t_clear_on_last_bit();
        t_late_clear();
        t_clear_in_data();
        t_unqualified();
        summary();
    end

endmodule